// File: doc/BRIEF.md
# Instrument Status Event Reporting Unit

This block gathers the live status conditions of an instrument into a small tree of latched event registers and raises a service request toward the host. Three condition groups feed it: an 8-bit standard group and two 16-bit groups, one for questionable conditions and one for operation conditions. Each group turns rising edges of its condition inputs into sticky event bits. It keeps an enable mask beside them and reduces the masked events to one summary bit.

The three summaries and an external output-queue-not-empty flag form a status byte. A second mask, the service request enable, selects which status byte bits may request service. The resulting request-service bit sits in the status byte and drives an active-low service request pin. A host reaches every register through a simple select/read/write bus. Read data is combinational on the select lines. A read strobe on an event register clears that register. A clear-status strobe empties all event registers in one cycle and leaves the masks as they are.

Top module: `stat_report_top`

## Requirements
- R1: An event bit is set on the clock edge that follows a 0-to-1 change of its condition bit. A condition that stays at 1 does not set the bit again once it has been cleared.
- R2: A set event bit stays set until its own event register is read with `reg_rd` or `clr_status` is pulsed. Reading one event register leaves the other two unchanged.
- R3: If a condition rises in the same cycle that its event register is read or cleared, the bit is 1 after that edge.
- R4: The standard event and enable registers are 8 bits wide. The questionable and operation ones are 16 bits wide. Read data is the plain binary register value, zero-extended to 16 bits. Enable registers read back what was written.
- R5: `clr_status` clears all three event registers on one edge. It leaves the three enable registers and the service request enable register unchanged.
- R6: Status byte layout: bit 3 is OR(questionable events AND enable), bit 4 is `oq_not_empty`, bit 5 is OR(standard events AND enable), bit 7 is OR(operation events AND enable), and bits 0 to 2 read 0. Reading the status byte does not clear it.
- R7: Status byte bit 6 is the OR of (status byte AND service request enable) over bits 0 to 5 and 7. Bit 6 of the service request enable register always reads 0.
- R8: `srq_n` is 0 exactly when status byte bit 6 is 1, and follows it in the same cycle.
- R9: Select codes: 0 standard events, 1 standard enable, 2 questionable events, 3 questionable enable, 4 operation events, 5 operation enable, 6 status byte, 7 service request enable. Writes to codes 0, 2, 4 and 6 have no effect.
- R10: After reset all registers read 0 and `srq_n` is 1. The condition history is 0, so a condition that is high when reset is released counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_cond | input | 8 | Standard group condition levels |
| ques_cond | input | 16 | Questionable group condition levels |
| oper_cond | input | 16 | Operation group condition levels |
| oq_not_empty | input | 1 | Output queue holds data |
| reg_sel | input | 3 | Register select code |
| reg_rd | input | 1 | Read strobe (clears a selected event register) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| clr_status | input | 1 | Clear-status command strobe |
| reg_rdata | output | 16 | Read data for the selected register |
| srq_n | output | 1 | Service request, active low |

## Verification
The assertions assume that every input is a clean synchronous level, settled before each rising edge, and that each strobe lasts one cycle per intended access. They make no assumption about how strobes combine: read, write and clear may land on the same cycle and on the same register. The bench changes inputs only at falling edges. It mixes sparse random condition toggles with random strobes, so edges often coincide with reads and clears, and it adds directed cycles for steady levels, same-cycle edges and masking.

// File: rtl/stat_report_pkg.sv
package stat_report_pkg;

  localparam int STD_W = 8;
  localparam int GRP_W = 16;
  localparam int SB_W  = 8;
  localparam int BUS_W = 16;

  localparam int SB_QUES = 3;
  localparam int SB_OQ   = 4;
  localparam int SB_STD  = 5;
  localparam int SB_RQS  = 6;
  localparam int SB_OPER = 7;

  typedef enum logic [2:0] {
    SEL_STD_EV  = 3'd0,
    SEL_STD_EN  = 3'd1,
    SEL_QUES_EV = 3'd2,
    SEL_QUES_EN = 3'd3,
    SEL_OPER_EV = 3'd4,
    SEL_OPER_EN = 3'd5,
    SEL_STB     = 3'd6,
    SEL_SRE     = 3'd7
  } reg_sel_e;

  // Status byte without the request-service bit.
  function automatic logic [SB_W-1:0] compose_status(
      input logic ques_sum, input logic oq_ne,
      input logic std_sum, input logic oper_sum);
    logic [SB_W-1:0] v;
    v = '0;
    v[SB_QUES] = ques_sum;
    v[SB_OQ]   = oq_ne;
    v[SB_STD]  = std_sum;
    v[SB_OPER] = oper_sum;
    return v;
  endfunction

  // Request-service summary: masked status bits, bit 6 excluded.
  function automatic logic request_bit(input logic [SB_W-1:0] sb,
                                       input logic [SB_W-1:0] sre);
    logic [SB_W-1:0] self_mask;
    self_mask = '1;
    self_mask[SB_RQS] = 1'b0;
    return |(sb & sre & self_mask);
  endfunction

endpackage

// File: rtl/stat_event_group.sv
module stat_event_group #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  input  logic         clr_all,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] ev,
  output logic [W-1:0] en,
  output logic [W-1:0] rise,
  output logic         summary
);

  logic [W-1:0] cond_q;
  logic [W-1:0] ev_kept;

  assign rise    = cond & ~cond_q;
  assign ev_kept = (rd_clr || clr_all) ? '0 : ev;
  assign summary = |(ev & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ev     <= '0;
      en     <= '0;
    end else begin
      cond_q <= cond;
      ev     <= ev_kept | rise;
      if (en_wr) en <= en_wdata;
    end
  end

endmodule

// File: rtl/stat_byte_unit.sv
module stat_byte_unit
  import stat_report_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ques_sum,
  input  logic            oq_ne,
  input  logic            std_sum,
  input  logic            oper_sum,
  input  logic            sre_wr,
  input  logic [SB_W-1:0] sre_wdata,
  output logic [SB_W-1:0] sb,
  output logic [SB_W-1:0] sre,
  output logic            rqs
);

  logic [SB_W-1:0] base;
  logic [SB_W-1:0] sre_mask;

  always_comb begin
    sre_mask = '1;
    sre_mask[SB_RQS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sre <= '0;
    else if (sre_wr) sre <= sre_wdata & sre_mask;
  end

  assign base = compose_status(ques_sum, oq_ne, std_sum, oper_sum);
  assign rqs  = request_bit(base, sre);

  always_comb begin
    sb = base;
    sb[SB_RQS] = rqs;
  end

endmodule

// File: rtl/stat_report_top.sv
module stat_report_top
  import stat_report_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STD_W-1:0] std_cond,
  input  logic [GRP_W-1:0] ques_cond,
  input  logic [GRP_W-1:0] oper_cond,
  input  logic             oq_not_empty,
  input  logic [2:0]       reg_sel,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [BUS_W-1:0] reg_wdata,
  input  logic             clr_status,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             srq_n
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  // Named access events
  logic std_rd_clr, ques_rd_clr, oper_rd_clr;
  logic std_en_wr, ques_en_wr, oper_en_wr, sre_wr;
  assign std_rd_clr  = reg_rd && (sel == SEL_STD_EV);
  assign ques_rd_clr = reg_rd && (sel == SEL_QUES_EV);
  assign oper_rd_clr = reg_rd && (sel == SEL_OPER_EV);
  assign std_en_wr   = reg_wr && (sel == SEL_STD_EN);
  assign ques_en_wr  = reg_wr && (sel == SEL_QUES_EN);
  assign oper_en_wr  = reg_wr && (sel == SEL_OPER_EN);
  assign sre_wr      = reg_wr && (sel == SEL_SRE);

  logic [STD_W-1:0] std_ev, std_en, std_rise;
  logic [GRP_W-1:0] ques_ev, ques_en, ques_rise;
  logic [GRP_W-1:0] oper_ev, oper_en, oper_rise;
  logic std_sum, ques_sum, oper_sum;
  logic [SB_W-1:0] sb, sre;
  logic rqs;

  stat_event_group #(.W(STD_W)) u_std (
    .clk(clk), .rst_n(rst_n), .cond(std_cond),
    .rd_clr(std_rd_clr), .clr_all(clr_status),
    .en_wr(std_en_wr), .en_wdata(reg_wdata[STD_W-1:0]),
    .ev(std_ev), .en(std_en), .rise(std_rise), .summary(std_sum)
  );

  stat_event_group #(.W(GRP_W)) u_ques (
    .clk(clk), .rst_n(rst_n), .cond(ques_cond),
    .rd_clr(ques_rd_clr), .clr_all(clr_status),
    .en_wr(ques_en_wr), .en_wdata(reg_wdata[GRP_W-1:0]),
    .ev(ques_ev), .en(ques_en), .rise(ques_rise), .summary(ques_sum)
  );

  stat_event_group #(.W(GRP_W)) u_oper (
    .clk(clk), .rst_n(rst_n), .cond(oper_cond),
    .rd_clr(oper_rd_clr), .clr_all(clr_status),
    .en_wr(oper_en_wr), .en_wdata(reg_wdata[GRP_W-1:0]),
    .ev(oper_ev), .en(oper_en), .rise(oper_rise), .summary(oper_sum)
  );

  stat_byte_unit u_stb (
    .clk(clk), .rst_n(rst_n),
    .ques_sum(ques_sum), .oq_ne(oq_not_empty),
    .std_sum(std_sum), .oper_sum(oper_sum),
    .sre_wr(sre_wr), .sre_wdata(reg_wdata[SB_W-1:0]),
    .sb(sb), .sre(sre), .rqs(rqs)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_STD_EV:  reg_rdata[STD_W-1:0] = std_ev;
      SEL_STD_EN:  reg_rdata[STD_W-1:0] = std_en;
      SEL_QUES_EV: reg_rdata[GRP_W-1:0] = ques_ev;
      SEL_QUES_EN: reg_rdata[GRP_W-1:0] = ques_en;
      SEL_OPER_EV: reg_rdata[GRP_W-1:0] = oper_ev;
      SEL_OPER_EN: reg_rdata[GRP_W-1:0] = oper_en;
      SEL_STB:     reg_rdata[SB_W-1:0]  = sb;
      SEL_SRE:     reg_rdata[SB_W-1:0]  = sre;
      default:     reg_rdata = '0;
    endcase
  end

  assign srq_n = ~rqs;

endmodule

// File: rtl/stat_report_chk.sv
module stat_report_chk
  import stat_report_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr_status,
  input logic             oq_not_empty,
  input logic             srq_n,
  input logic             std_rd_clr,
  input logic             ques_rd_clr,
  input logic             std_en_wr,
  input logic [STD_W-1:0] std_ev,
  input logic [STD_W-1:0] std_en,
  input logic [STD_W-1:0] std_rise,
  input logic [GRP_W-1:0] ques_ev,
  input logic [GRP_W-1:0] ques_rise,
  input logic [SB_W-1:0]  sb,
  input logic [SB_W-1:0]  sre
);

  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((std_ev & $past(std_rise)) == $past(std_rise)));

  assert_event_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(std_rd_clr || clr_status) |=> ((std_ev & $past(std_ev)) == $past(std_ev)));

  assert_ques_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ques_rd_clr || clr_status) |=> ((ques_ev & $past(ques_ev)) == $past(ques_ev)));

  assert_read_keeps_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    std_rd_clr |=> (std_ev == $past(std_rise)));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> (ques_ev == $past(ques_rise)));

  assert_clear_keeps_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !std_en_wr) |=> $stable(std_en));

  assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sb[2:0] == 3'b000);

  assert_queue_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sb[SB_OQ] == oq_not_empty);

  assert_sre_self_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sre[SB_RQS] == 1'b0);

  assert_srq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srq_n == !sb[SB_RQS]);

endmodule

bind stat_report_top stat_report_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_status(clr_status),
  .oq_not_empty(oq_not_empty), .srq_n(srq_n),
  .std_rd_clr(std_rd_clr), .ques_rd_clr(ques_rd_clr), .std_en_wr(std_en_wr),
  .std_ev(std_ev), .std_en(std_en), .std_rise(std_rise),
  .ques_ev(ques_ev), .ques_rise(ques_rise), .sb(sb), .sre(sre)
);

// File: tb/tb_stat_report_top.sv
module tb_stat_report_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  std_cond = '0;
  logic [15:0] ques_cond = '0;
  logic [15:0] oper_cond = '0;
  logic        oq_not_empty = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        clr_status = 1'b0;
  logic [15:0] reg_rdata;
  logic        srq_n;

  always #10 clk = ~clk;  // 50 MHz

  stat_report_top dut (
    .clk(clk), .rst_n(rst_n), .std_cond(std_cond), .ques_cond(ques_cond),
    .oper_cond(oper_cond), .oq_not_empty(oq_not_empty), .reg_sel(reg_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .clr_status(clr_status), .reg_rdata(reg_rdata), .srq_n(srq_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model
  logic [7:0]  m_sev, m_sen, m_sprev;
  logic [15:0] m_qev, m_qen, m_qprev, m_oev, m_oen, m_oprev;
  logic [7:0]  m_sre;

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    logic any;
    s = 8'h00;
    if ((m_qev & m_qen) != 16'h0) s = s | 8'b0000_1000;
    if (oq_not_empty)             s = s | 8'b0001_0000;
    if ((m_sev & m_sen) != 8'h0)  s = s | 8'b0010_0000;
    if ((m_oev & m_oen) != 16'h0) s = s | 8'b1000_0000;
    any = 1'b0;
    for (int b = 0; b < 8; b++)
      if (b != 6 && s[b] && m_sre[b]) any = 1'b1;
    if (any) s = s | 8'b0100_0000;
    return s;
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] sel);
    case (sel)
      3'd0: return {8'h00, m_sev};
      3'd1: return {8'h00, m_sen};
      3'd2: return m_qev;
      3'd3: return m_qen;
      3'd4: return m_oev;
      3'd5: return m_oen;
      3'd6: return {8'h00, exp_status()};
      default: return {8'h00, m_sre};
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sev = '0; m_sen = '0; m_sprev = '0;
    m_qev = '0; m_qen = '0; m_qprev = '0;
    m_oev = '0; m_oen = '0; m_oprev = '0;
    m_sre = '0;
  endtask

  // One bus cycle: drive at falling edge, check before rising edge, update model.
  task automatic cyc(input logic [7:0] sc, input logic [15:0] qc,
                     input logic [15:0] oc, input logic oq,
                     input logic [2:0] sel, input logic rd, input logic wr,
                     input logic [15:0] wd, input logic clr, input string req);
    @(negedge clk);
    std_cond = sc; ques_cond = qc; oper_cond = oc; oq_not_empty = oq;
    reg_sel = sel; reg_rd = rd; reg_wr = wr; reg_wdata = wd; clr_status = clr;
    #3;
    check(reg_rdata, exp_read(sel), req);
    check({15'h0, srq_n}, {15'h0, ~exp_status()[6]}, "R8 srq_n");
    @(posedge clk);
    m_sev = ((clr || (rd && sel == 3'd0)) ? 8'h0  : m_sev) | (sc & ~m_sprev);
    m_qev = ((clr || (rd && sel == 3'd2)) ? 16'h0 : m_qev) | (qc & ~m_qprev);
    m_oev = ((clr || (rd && sel == 3'd4)) ? 16'h0 : m_oev) | (oc & ~m_oprev);
    m_sprev = sc; m_qprev = qc; m_oprev = oc;
    if (wr) begin
      if (sel == 3'd1) m_sen = wd[7:0];
      if (sel == 3'd3) m_qen = wd;
      if (sel == 3'd5) m_oen = wd;
      if (sel == 3'd7) m_sre = wd[7:0] & 8'hBF;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  sc;
    logic [15:0] qc, oc;
    logic        oq;
    int          seed;
    seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    #3;
    check(reg_rdata, 16'h0, "R10 reset read");
    check({15'h0, srq_n}, 16'h1, "R10 reset srq_n");
    @(negedge clk);
    rst_n = 1'b1;

    // R10: all registers zero after reset
    for (int s = 0; s < 8; s++)
      cyc(8'h0, 16'h0, 16'h0, 1'b0, 3'(s), 1'b0, 1'b0, 16'h0, 1'b0, "R10 R9 reset map");

    // R1: edge sets, steady level does not reassert after read
    cyc(8'h01, 16'h0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R1 edge");
    cyc(8'h01, 16'h0, 16'h0, 1'b0, 3'd0, 1'b1, 1'b0, 16'h0, 1'b0, "R1 read set");
    cyc(8'h01, 16'h0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R1 steady");
    // R3: edge on same cycle as read is kept
    cyc(8'h00, 16'h0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R3 prep");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd0, 1'b1, 1'b0, 16'h0, 1'b0, "R3 read+edge");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R3 kept");
    // R9: writes to event and status byte selects ignored
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b1, 16'hFFFF, 1'b0, "R9 wr ev");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd6, 1'b0, 1'b1, 16'hFFFF, 1'b0, "R9 wr stb");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R9 ev unchanged");
    // R4 R7: enables and sre
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA5C3, 1'b0, "R4 wr std en");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd1, 1'b0, 1'b0, 16'h0, 1'b0, "R4 std en 8 bits");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b1, 16'hFFFF, 1'b0, "R7 wr sre");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 16'h0, 1'b0, "R7 sre bit6 zero");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd6, 1'b0, 1'b0, 16'h0, 1'b0, "R6 R8 std summary");
    cyc(8'h02, 16'h0, 16'h0, 1'b0, 3'd6, 1'b1, 1'b0, 16'h0, 1'b0, "R6 stb read no clear");
    cyc(8'h02, 16'h0, 16'h0, 1'b1, 3'd6, 1'b0, 1'b0, 16'h0, 1'b0, "R6 oq bit");
    // R5: clear-status with enables kept
    cyc(8'h02, 16'h8001, 16'h4000, 1'b0, 3'd3, 1'b0, 1'b1, 16'hFFFF, 1'b0, "R4 ques en");
    cyc(8'h02, 16'h8001, 16'h4000, 1'b0, 3'd2, 1'b0, 1'b0, 16'h0, 1'b1, "R5 clear");
    cyc(8'h02, 16'h8001, 16'h4000, 1'b0, 3'd2, 1'b0, 1'b0, 16'h0, 1'b0, "R5 ques cleared");
    cyc(8'h02, 16'h8001, 16'h4000, 1'b0, 3'd4, 1'b0, 1'b0, 16'h0, 1'b0, "R5 oper cleared");
    cyc(8'h02, 16'h8001, 16'h4000, 1'b0, 3'd3, 1'b0, 1'b0, 16'h0, 1'b0, "R5 en kept");
    cyc(8'h02, 16'h8001, 16'h4000, 1'b0, 3'd7, 1'b0, 1'b0, 16'h0, 1'b0, "R5 sre kept");
    // R2: read of one register leaves others
    cyc(8'h00, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R2 prep");
    cyc(8'h10, 16'h0100, 16'h0010, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R2 edges");
    cyc(8'h00, 16'h0000, 16'h0000, 1'b0, 3'd2, 1'b1, 1'b0, 16'h0, 1'b0, "R2 read ques");
    cyc(8'h00, 16'h0000, 16'h0000, 1'b0, 3'd4, 1'b0, 1'b0, 16'h0, 1'b0, "R2 oper held");
    cyc(8'h00, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R2 std held");
    // R8: masking off blocks request
    cyc(8'h00, 16'h0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b1, 16'h0000, 1'b0, "R8 sre off");
    cyc(8'h00, 16'h0, 16'h0, 1'b0, 3'd6, 1'b0, 1'b0, 16'h0, 1'b0, "R8 no request");

    // Random phase
    sc = 8'h0; qc = 16'h0; oc = 16'h0; oq = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] sel;
      logic rd, wr, clr;
      sc = sc ^ 8'($urandom & $urandom & $urandom);
      qc = qc ^ 16'($urandom & $urandom & $urandom);
      oc = oc ^ 16'($urandom & $urandom & $urandom);
      if ($urandom_range(15) == 0) oq = ~oq;
      sel = 3'($urandom_range(7));
      rd  = ($urandom_range(3) == 0);
      wr  = ($urandom_range(7) == 0);
      clr = ($urandom_range(31) == 0);
      cyc(sc, qc, oc, oq, sel, rd, wr, 16'($urandom), clr, "R2 R4 R6 R9 random");
    end
    finish_run();
  end

endmodule